// File: doc/BRIEF.md
# Memory Test Access Port

This block is the boundary-scan test port of a synchronous memory device. It has no dedicated test reset pin. Serial commands arrive on a test mode select line and data on a serial input, both sampled on the rising edge of the test clock. The serial output and its enable are updated on the falling edge. A sixteen-state controller steps through the standard scan sequence. It places one register at a time between the serial input and the serial output: the 3-bit instruction register, a 1-bit bypass stage, a 32-bit identification register or the boundary register.

The identification register captures a fixed code. That code contains a presence bit, the compressed manufacturer code, a width code, a depth code and a revision field. The build is chosen by a parameter: the wide build has a 70-bit boundary register and the narrow build a 51-bit one. The boundary register captures the I/O ring inputs. The last few positions, nearest the serial input, are placeholders that always capture 1. The test logic is reset by the chip's power-on reset or by five rising clock edges with the mode select held high. Undriven mode-select and data pins are expected to be pulled high at the pad, so that they read as 1.

Top module: `mem_tap`

## Requirements
- R1: While `por_n` is low, the controller is in Test-Logic-Reset, the active instruction is IDCODE (3'b001) and `tdo_oe` is 0; after release, the first data scan returns the identification code.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state. The active instruction then returns to IDCODE.
- R3: The controller follows the standard 16-state transitions, including the pause and exit-2 states. A data scan interrupted by a pause resumes with the next bit and loses no bit.
- R4: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR.
- R5: The instruction register is 3 bits, shifted LSB first. Capture-IR loads 3'b001, so 1, 0, 0 appear on `tdo`. The shifted value becomes active only in Update-IR, on the falling edge.
- R6: With IDCODE active, Capture-DR loads a 32-bit code, shifted bit 0 first. The code has bit 0 = 1, bits 11:1 = 11'b00000001110 and bits 17:12 = 0. Bits 22:18 are 5'b00100 in the wide build and 5'b00011 in the narrow build. Bits 27:23 are 5'b00101 (wide) or 5'b00110 (narrow). Bits 31:28 hold the revision (default 0). Data on `tdi` emerges after 32 bits.
- R7: Opcode 3'b111 (BYPASS) selects a 1-bit register. It captures 0, and data on `tdi` appears on `tdo` one shift later.
- R8: Opcodes 3'b000 (EXTEST) and 3'b010 (SAMPLE/PRELOAD) select the boundary register, 70 bits (wide) or 51 bits (narrow). Capture-DR loads `ring_in[k]` into position k+1, and position 1 is shifted out first. The top two positions capture 1. Data on `tdi` emerges after the full length.
- R9: The unassigned opcodes 3'b011, 3'b100, 3'b101 and 3'b110 select the bypass register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset of the test logic, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in, sampled on the rising edge |
| ring_in | input | PIN_BITS | I/O ring values captured by the boundary register (68 wide, 49 narrow) |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo`, high only in the shift states |

## Verification
The bench builds two copies side by side on the same serial inputs: one with `WIDE` = 1 and one with `WIDE` = 0, both with revision 0 and two placeholder positions. This puts both identification codes, both boundary lengths and the placeholder positions of each length within reach in the same scans. It also shows that the serial paths differ only where the build parameter says they should. Every one of the eight opcodes is scanned directly and then again in random order with random ring values and random serial data.

// File: rtl/mem_tap_pkg.sv
package mem_tap_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BSCAN} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST      = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE      = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE      = 3'b010;
  localparam logic [IR_W-1:0] OP_BYPASS      = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  function automatic tap_state_e next_state(tap_state_e s, logic m);
    next_state = s;
    case (s)
      ST_RESET:  next_state = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   next_state = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: next_state = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: next_state = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  next_state = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: next_state = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: next_state = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: next_state = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: next_state = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: next_state = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: next_state = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  next_state = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: next_state = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: next_state = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: next_state = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: next_state = m ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

  function automatic dr_sel_e dr_select(logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE: dr_select = DR_BSCAN;
      OP_IDCODE:            dr_select = DR_IDENT;
      default:              dr_select = DR_BYPASS;
    endcase
  endfunction

  function automatic int bsr_len(bit wide);
    return wide ? 70 : 51;
  endfunction

  function automatic logic [ID_W-1:0] id_code(bit wide, logic [3:0] rev);
    logic [4:0] depth_c;
    logic [4:0] width_c;
    depth_c = wide ? 5'b00101 : 5'b00110;
    width_c = wide ? 5'b00100 : 5'b00011;
    return {rev, depth_c, width_c, 6'b000000, 11'b000_0000_1110, 1'b1};
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import mem_tap_pkg::*;
(
  input  logic tck,
  input  logic por_n,
  input  logic tms,
  output logic at_reset,
  output logic cap_dr,
  output logic sh_dr,
  output logic cap_ir,
  output logic sh_ir,
  output logic upd_ir
);

  tap_state_e state;
  logic [2:0] ones_run;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      state    <= ST_RESET;
      ones_run <= 3'd0;
    end else begin
      state    <= next_state(state, tms);
      ones_run <= tms ? ((ones_run == 3'd5) ? 3'd5 : ones_run + 3'd1) : 3'd0;
    end
  end

  assign at_reset = (state == ST_RESET);
  assign cap_dr   = (state == ST_CAP_DR);
  assign sh_dr    = (state == ST_SH_DR);
  assign cap_ir   = (state == ST_CAP_IR);
  assign sh_ir    = (state == ST_SH_IR);
  assign upd_ir   = (state == ST_UPD_IR);

  // R2
  five_high_reset_chk: assert property (@(posedge tck) disable iff (!por_n)
    (ones_run == 3'd5) |-> (state == ST_RESET));

  // R3
  pause_dr_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_PAU_DR && !tms) |=> (state == ST_PAU_DR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import mem_tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  logic            at_reset,
  input  logic            cap_ir,
  input  logic            sh_ir,
  input  logic            upd_ir,
  output logic            ir_lsb,
  output logic [IR_W-1:0] instr
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)      ir_sr <= IR_CAPTURE_PAT;
    else if (cap_ir) ir_sr <= IR_CAPTURE_PAT;
    else if (sh_ir)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n)        instr <= OP_IDCODE;
    else if (at_reset) instr <= OP_IDCODE;
    else if (upd_ir)   instr <= ir_sr;
  end

  assign ir_lsb = ir_sr[0];

  // R5
  ir_capture_pat_chk: assert property (@(posedge tck) disable iff (!por_n)
    cap_ir |=> (ir_sr == 3'b001));

  // R5
  instr_hold_chk: assert property (@(negedge tck) disable iff (!por_n)
    !(upd_ir || at_reset) |=> $stable(instr));

  // R2
  reset_idcode_chk: assert property (@(negedge tck) disable iff (!por_n)
    at_reset |=> (instr == 3'b001));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import mem_tap_pkg::*;
#(
  parameter int              BSR_LEN  = 70,
  parameter int              PIN_BITS = 68,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_001D
) (
  input  logic                tck,
  input  logic                por_n,
  input  logic                tdi,
  input  logic                cap_dr,
  input  logic                sh_dr,
  input  dr_sel_e             sel,
  input  logic [PIN_BITS-1:0] ring_in,
  output logic                dr_lsb
);

  logic                byp;
  logic [ID_W-1:0]     id_sr;
  logic [BSR_LEN-1:0]  bsr;
  logic [BSR_LEN-1:0]  bsr_cap;

  for (genvar g = 0; g < BSR_LEN; g++) begin : g_cap
    if (g < PIN_BITS) begin : g_pin
      assign bsr_cap[g] = ring_in[g];
    end else begin : g_hold
      assign bsr_cap[g] = 1'b1;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp   <= 1'b0;
      id_sr <= ID_VALUE;
      bsr   <= '1;
    end else begin
      if (sel == DR_BYPASS) begin
        if (cap_dr)     byp <= 1'b0;
        else if (sh_dr) byp <= tdi;
      end
      if (sel == DR_IDENT) begin
        if (cap_dr)     id_sr <= ID_VALUE;
        else if (sh_dr) id_sr <= {tdi, id_sr[ID_W-1:1]};
      end
      if (sel == DR_BSCAN) begin
        if (cap_dr)     bsr <= bsr_cap;
        else if (sh_dr) bsr <= {tdi, bsr[BSR_LEN-1:1]};
      end
    end
  end

  always_comb begin
    case (sel)
      DR_IDENT: dr_lsb = id_sr[0];
      DR_BSCAN: dr_lsb = bsr[0];
      default:  dr_lsb = byp;
    endcase
  end

  // R7
  bypass_capture_zero_chk: assert property (@(posedge tck) disable iff (!por_n)
    (cap_dr && sel == DR_BYPASS) |=> !byp);

  // R6
  id_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
    (cap_dr && sel == DR_IDENT) |=> (id_sr == ID_VALUE));

  // R8
  bsr_hold_ones_chk: assert property (@(posedge tck) disable iff (!por_n)
    (cap_dr && sel == DR_BSCAN) |=> (&bsr[BSR_LEN-1:PIN_BITS]));

  // R8
  bsr_pin_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
    (cap_dr && sel == DR_BSCAN) |=> (bsr[PIN_BITS-1:0] == $past(ring_in)));

endmodule

// File: rtl/mem_tap.sv
module mem_tap
  import mem_tap_pkg::*;
#(
  parameter bit         WIDE      = 1'b1,
  parameter logic [3:0] REVISION  = 4'h0,
  parameter int         HOLD_BITS = 2,
  localparam int        BSR_LEN   = bsr_len(WIDE),
  localparam int        PIN_BITS  = BSR_LEN - HOLD_BITS
) (
  input  logic                tck,
  input  logic                por_n,
  input  logic                tms,
  input  logic                tdi,
  input  logic [PIN_BITS-1:0] ring_in,
  output logic                tdo,
  output logic                tdo_oe
);

  localparam logic [ID_W-1:0] ID_VALUE = id_code(WIDE, REVISION);

  logic            at_reset, cap_dr, sh_dr, cap_ir, sh_ir, upd_ir;
  logic            ir_lsb, dr_lsb;
  logic [IR_W-1:0] instr;
  dr_sel_e         dr_sel;

  tap_fsm i_fsm (
    .tck(tck), .por_n(por_n), .tms(tms),
    .at_reset(at_reset), .cap_dr(cap_dr), .sh_dr(sh_dr),
    .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir)
  );

  tap_ir i_ir (
    .tck(tck), .por_n(por_n), .tdi(tdi),
    .at_reset(at_reset), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
    .ir_lsb(ir_lsb), .instr(instr)
  );

  assign dr_sel = dr_select(instr);

  tap_dr #(.BSR_LEN(BSR_LEN), .PIN_BITS(PIN_BITS), .ID_VALUE(ID_VALUE)) i_dr (
    .tck(tck), .por_n(por_n), .tdi(tdi),
    .cap_dr(cap_dr), .sh_dr(sh_dr), .sel(dr_sel),
    .ring_in(ring_in), .dr_lsb(dr_lsb)
  );

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= sh_ir | sh_dr;
      if (sh_ir)      tdo <= ir_lsb;
      else if (sh_dr) tdo <= dr_lsb;
    end
  end

  // R4
  oe_matches_shift_chk: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == (sh_ir | sh_dr));

endmodule

// File: tb/test_mem_tap.sv
module test_mem_tap;

  logic        tck = 1'b0;
  logic        por_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b1;
  logic [67:0] ring36 = '0;
  logic [48:0] ring18 = '0;
  logic        tdo36, oe36, tdo18, oe18;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 tck = ~tck;

  mem_tap i_mem_tap (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
    .ring_in(ring36), .tdo(tdo36), .tdo_oe(oe36)
  );

  mem_tap #(.WIDE(1'b0)) i_mem_tap_n (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
    .ring_in(ring18), .tdo(tdo18), .tdo_oe(oe18)
  );

  function automatic logic [31:0] exp_id(bit wide);
    logic [4:0] dep = wide ? 5'd5 : 5'd6;
    logic [4:0] wid = wide ? 5'd4 : 5'd3;
    return (32'(dep) << 23) | (32'(wid) << 18) | (32'h00E << 1) | 32'd1;
  endfunction

  function automatic logic [79:0] exp_scan(logic [2:0] op, bit wide,
                                           logic [79:0] ring, logic [79:0] din);
    logic [79:0] r;
    int len = wide ? 70 : 51;
    logic [31:0] id = exp_id(wide);
    for (int i = 0; i < 80; i++) begin
      if (op == 3'd0 || op == 3'd2)
        r[i] = (i < len) ? ((i < len - 2) ? ring[i] : 1'b1) : din[i - len];
      else if (op == 3'd1)
        r[i] = (i < 32) ? id[i] : din[i - 32];
      else
        r[i] = (i == 0) ? 1'b0 : din[i - 1];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [79:0] act, logic [79:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic scan_dr(input int n, input logic [79:0] din,
                         output logic [79:0] o36, output logic [79:0] o18);
    o36 = '0;
    o18 = '0;
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    for (int i = 0; i < n; i++) begin
      o36[i] = tdo36;
      o18[i] = tdo18;
      tick(i == n - 1, din[i]);
    end
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] c36,
                         output logic [2:0] c18);
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      c36[i] = tdo36;
      c18[i] = tdo18;
      tick(i == 2, op[i]);
    end
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
  endtask

  task automatic run_op(input logic [2:0] op);
    logic [2:0]  c36, c18;
    logic [79:0] din, o36, o18, e36, e18, mask36, mask18;
    string       tag;
    load_ir(op, c36, c18);
    chk(c36 == 3'b001 && c18 == 3'b001, "R5 ir capture",
        {c36, 1'b0, c18}, {3'b001, 1'b0, 3'b001});
    ring36 = {$urandom(), $urandom(), $urandom()};
    ring18 = {$urandom(), $urandom()};
    din = {$urandom(), $urandom(), $urandom()};
    scan_dr(80, din, o36, o18);
    e36 = exp_scan(op, 1'b1, {12'hFFF, ring36}, din);
    e18 = exp_scan(op, 1'b0, {31'h7FFFFFFF, ring18}, din);
    mask36 = '1;
    mask18 = '1;
    case (op)
      3'd0, 3'd2: tag = "R8 boundary scan";
      3'd1:       tag = "R6 idcode scan";
      3'd7:       tag = "R7 bypass scan";
      default:    tag = "R9 unassigned opcode bypass";
    endcase
    chk((o36 & mask36) == (e36 & mask36), {tag, " wide"}, o36, e36);
    chk((o18 & mask18) == (e18 & mask18), {tag, " narrow"}, o18, e18);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [79:0] o36, o18, din;
    logic [31:0] b36, b18;
    logic [2:0]  c36, c18;
    void'($urandom(32'd2024));

    // R1: reset state
    #22;
    por_n = 1'b1;
    @(negedge tck);
    #1;
    chk(oe36 == 1'b0 && oe18 == 1'b0, "R1 oe low after reset",
        {oe36, oe18}, 2'b00);
    tick(1'b0, 1'b1);
    din = {$urandom(), $urandom(), $urandom()};
    scan_dr(40, din, o36, o18);
    chk(o36[39:0] == {din[7:0], exp_id(1'b1)}, "R1 idcode after reset wide",
        o36, {din[7:0], exp_id(1'b1)});
    chk(o18[39:0] == {din[7:0], exp_id(1'b0)}, "R1 idcode after reset narrow",
        o18, {din[7:0], exp_id(1'b0)});

    // R4: enable moves on the falling edge only
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    tms = 1'b0;
    @(posedge tck);
    #1;
    chk(oe36 == 1'b0, "R4 oe not yet high after rising edge", oe36, 1'b0);
    @(negedge tck);
    #1;
    chk(oe36 == 1'b1 && oe18 == 1'b1, "R4 oe high in shift-DR",
        {oe36, oe18}, 2'b11);
    chk(tdo36 == 1'b1 && tdo18 == 1'b1, "R4 first idcode bit on falling edge",
        {tdo36, tdo18}, 2'b11);
    tick(1'b1, 1'b1);
    chk(oe36 == 1'b0, "R4 oe low in exit1-DR", oe36, 1'b0);
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);

    // R3: pause in the middle of a scan
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) begin
      b36[i] = tdo36;
      b18[i] = tdo18;
      tick(1'b0, 1'b0);
    end
    b36[10] = tdo36;
    b18[10] = tdo18;
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk(oe36 == 1'b0, "R3 oe low in pause-DR", oe36, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 11; i < 32; i++) begin
      b36[i] = tdo36;
      b18[i] = tdo18;
      tick(i == 31, 1'b0);
    end
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    chk(b36 == exp_id(1'b1), "R3 paused scan wide", b36, exp_id(1'b1));
    chk(b18 == exp_id(1'b0), "R3 paused scan narrow", b18, exp_id(1'b0));

    // R2: five ones from inside shift-DR
    load_ir(3'b111, c36, c18);
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1);
    chk(oe36 == 1'b0, "R2 oe low after five ones", oe36, 1'b0);
    tick(1'b0, 1'b1);
    din = {$urandom(), $urandom(), $urandom()};
    scan_dr(40, din, o36, o18);
    chk(o36[31:0] == exp_id(1'b1), "R2 idcode restored wide",
        o36, exp_id(1'b1));
    chk(o18[31:0] == exp_id(1'b0), "R2 idcode restored narrow",
        o18, exp_id(1'b0));

    // directed pass over all opcodes, then random order
    for (int op = 0; op < 8; op++) run_op(3'(op));
    for (int k = 0; k < 12; k++) run_op(3'($urandom() % 8));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule